// File: doc/BRIEF.md
# Descriptor Ring Kick and Completion Tracker

This block follows one direction of a descriptor ring that lives in host memory and is shared between software and a DMA engine. Software posts work by writing a kick index, the position one past the newest valid descriptor. The tracker holds a hardware position that walks the ring toward the kick. At each step it raises a fetch request and forms the byte address of the descriptor it points at. A fetch-done pulse moves the hardware position forward by one descriptor.

A separate processed-done pulse moves a completion index, which trails the hardware position. Software reads the completion index to find which descriptors it may reclaim. Every index wraps at the selected ring size. In the receive variant, kicks must be multiples of four. A kick that breaks this rule is discarded and sets a sticky error.

Bus traffic, descriptor decoding and payload movement are outside this block. The fetch request and fetch-done pair stands in for all of them.

Top module: `desc_ring_tracker`

## Requirements
- R1: After reset, `postedKick`, `hwPos` and `completion` are 0, `fetchReq` is 0 and `kickErr` is 0.
- R2: A `kickValid` cycle with an accepted kick stores `kickIndex` ANDed with (ring entries − 1). The stored value appears on `postedKick` in the next cycle.
- R3: `fetchReq` is 1 exactly when `cfgWord[0]` (enable) is 1 and `hwPos` differs from `postedKick`. When the ring is empty or the channel is disabled, it is 0.
- R4: `fetchDone` in a cycle where `fetchReq` is 1 moves `hwPos` to (`hwPos` + 1) modulo the ring size. `fetchDone` while `fetchReq` is 0 leaves `hwPos` unchanged.
- R5: `procDone` while `completion` differs from `hwPos` moves `completion` forward by one, modulo the ring size. `procDone` while `completion` equals `hwPos` is ignored.
- R6: `fetchAddr` equals {`baseHi`, 11 zero bits} + 16 × `hwPos`. This gives a 2 KB aligned table of 16-byte descriptors.
- R7: `cfgWord[4:1]` selects the ring size. Code c in the range 0..8 gives 32·2^c entries, so 0 gives 32 and 8 gives 8192. Codes 9..15 act as 8192.
- R8: In the receive variant (`RECEIVE`=1, the default), a kick whose `kickIndex[1:0]` is not 00 leaves `postedKick` unchanged. It also sets `kickErr`, which stays 1 until reset.
- R9: `hwPos` and `completion` step from the last entry (size − 1) back to 0.
- R10: A kick, a fetch-done and a processed-done that land in the same cycle all take effect in that cycle. Each one is judged on the state held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWord | input | 5 | Bit 0: enable. Bits 4:1: ring size code |
| baseHi | input | 53 | Descriptor table base, address bits 63:11 |
| kickValid | input | 1 | Kick write strobe |
| kickIndex | input | 13 | Kick value: one past the last valid descriptor |
| fetchDone | input | 1 | Descriptor at `hwPos` has been fetched |
| procDone | input | 1 | Oldest outstanding descriptor has been processed |
| fetchReq | output | 1 | A descriptor is waiting to be fetched |
| fetchAddr | output | 64 | Byte address of the descriptor at `hwPos` |
| hwPos | output | 13 | Hardware position in the ring |
| completion | output | 13 | One past the last processed descriptor |
| postedKick | output | 13 | Kick value currently held |
| kickErr | output | 1 | Sticky flag for a misaligned receive kick |

## Verification
A new kick can arrive in the same cycle that a fetch-done consumes the last descriptor before the old kick. Likewise, a processed-done can coincide with a fetch-done. The bench drives these pulses together on one falling edge. After the rising edge it checks that the kick was stored and that the position advanced. It also checks that a processed-done arriving while `completion` still equals `hwPos` is dropped, even though the same edge moves `hwPos` ahead.

// File: rtl/ring_trk_pkg.sv
package ring_trk_pkg;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic loadKick;
    logic flagErr;
    logic stepFetch;
    logic stepDone;
  } ringStrobes_t;

endpackage

// File: rtl/desc_ring_dp.sv
module desc_ring_dp
  import ring_trk_pkg::*;
#(
  parameter int IDX_W     = 13,
  parameter int ADDR_W    = 64,
  parameter int ALIGN_LOG = 11,
  parameter int DESC_LOG  = 4,
  parameter int MIN_LOG   = 5,
  parameter int CODE_W    = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [CODE_W-1:0]           sizeCode,
  input  logic [ADDR_W-ALIGN_LOG-1:0] baseHi,
  input  logic [IDX_W-1:0]            kickIndex,
  input  ringStrobes_t                strobes,
  output logic [IDX_W-1:0]            postedKick,
  output logic [IDX_W-1:0]            hwPos,
  output logic [IDX_W-1:0]            completion,
  output logic [ADDR_W-1:0]           fetchAddr,
  output logic                        ringEmpty,
  output logic                        workPending
);
  localparam int MAX_CODE = IDX_W - MIN_LOG;

  logic [CODE_W-1:0] effCode;
  logic [IDX_W:0]    entries;
  logic [IDX_W-1:0]  idxMask;
  logic [IDX_W-1:0]  hwNext;
  logic [IDX_W-1:0]  doneNext;

  // ring size decode, oversized codes clamp to the largest ring
  always_comb begin
    effCode = (sizeCode > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : sizeCode;
    entries = (IDX_W+1)'(1) << (32'(effCode) + MIN_LOG);
    idxMask = IDX_W'(entries - 1'b1);
  end

  assign hwNext      = (hwPos + 1'b1) & idxMask;
  assign doneNext    = (completion + 1'b1) & idxMask;
  assign ringEmpty   = (hwPos == postedKick);
  assign workPending = (completion != hwPos);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      postedKick <= '0;
      hwPos      <= '0;
      completion <= '0;
    end else begin
      if (strobes.loadKick)  postedKick <= kickIndex & idxMask;
      if (strobes.stepFetch) hwPos      <= hwNext;
      if (strobes.stepDone)  completion <= doneNext;
    end
  end

  assign fetchAddr = {baseHi, {ALIGN_LOG{1'b0}}} + (ADDR_W'(hwPos) << DESC_LOG);

endmodule

// File: rtl/desc_ring_ctrl.sv
module desc_ring_ctrl
  import ring_trk_pkg::*;
#(
  parameter bit RECEIVE = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         enable,
  input  logic         kickValid,
  input  logic [1:0]   kickLow,
  input  logic         ringEmpty,
  input  logic         workPending,
  input  logic         fetchDone,
  input  logic         procDone,
  output ringStrobes_t strobes,
  output logic         fetchReq,
  output logic         kickErr
);
  logic kickAligned;

  generate
    if (RECEIVE) begin : g_rxAlign
      assign kickAligned = (kickLow == 2'b00);
    end else begin : g_txAny
      assign kickAligned = 1'b1;
    end
  endgenerate

  assign fetchReq = enable && !ringEmpty;

  always_comb begin
    strobes.loadKick  = kickValid && kickAligned;
    strobes.flagErr   = kickValid && !kickAligned;
    strobes.stepFetch = fetchReq && fetchDone;
    strobes.stepDone  = procDone && workPending;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                kickErr <= 1'b0;
    else if (strobes.flagErr) kickErr <= 1'b1;
  end

endmodule

// File: rtl/desc_ring_tracker.sv
module desc_ring_tracker
  import ring_trk_pkg::*;
#(
  parameter int IDX_W     = 13,
  parameter int ADDR_W    = 64,
  parameter int ALIGN_LOG = 11,
  parameter int DESC_LOG  = 4,
  parameter int MIN_LOG   = 5,
  parameter int CODE_W    = 4,
  parameter bit RECEIVE   = 1'b1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [CODE_W:0]             cfgWord,
  input  logic [ADDR_W-ALIGN_LOG-1:0] baseHi,
  input  logic                        kickValid,
  input  logic [IDX_W-1:0]            kickIndex,
  input  logic                        fetchDone,
  input  logic                        procDone,
  output logic                        fetchReq,
  output logic [ADDR_W-1:0]           fetchAddr,
  output logic [IDX_W-1:0]            hwPos,
  output logic [IDX_W-1:0]            completion,
  output logic [IDX_W-1:0]            postedKick,
  output logic                        kickErr
);
  ringStrobes_t strobes;
  logic         ringEmpty;
  logic         workPending;

  desc_ring_ctrl #(.RECEIVE(RECEIVE)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (cfgWord[0]),
    .kickValid  (kickValid),
    .kickLow    (kickIndex[1:0]),
    .ringEmpty  (ringEmpty),
    .workPending(workPending),
    .fetchDone  (fetchDone),
    .procDone   (procDone),
    .strobes    (strobes),
    .fetchReq   (fetchReq),
    .kickErr    (kickErr)
  );

  desc_ring_dp #(
    .IDX_W(IDX_W), .ADDR_W(ADDR_W), .ALIGN_LOG(ALIGN_LOG),
    .DESC_LOG(DESC_LOG), .MIN_LOG(MIN_LOG), .CODE_W(CODE_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .sizeCode   (cfgWord[CODE_W:1]),
    .baseHi     (baseHi),
    .kickIndex  (kickIndex),
    .strobes    (strobes),
    .postedKick (postedKick),
    .hwPos      (hwPos),
    .completion (completion),
    .fetchAddr  (fetchAddr),
    .ringEmpty  (ringEmpty),
    .workPending(workPending)
  );

endmodule

// File: rtl/desc_ring_tracker_chk.sv
module desc_ring_tracker_chk #(
  parameter int IDX_W     = 13,
  parameter int ADDR_W    = 64,
  parameter int ALIGN_LOG = 11,
  parameter int DESC_LOG  = 4,
  parameter int MIN_LOG   = 5,
  parameter int CODE_W    = 4,
  parameter bit RECEIVE   = 1'b1
) (
  input logic                        clk,
  input logic                        rstN,
  input logic [CODE_W:0]             cfgWord,
  input logic [ADDR_W-ALIGN_LOG-1:0] baseHi,
  input logic                        kickValid,
  input logic [IDX_W-1:0]            kickIndex,
  input logic                        fetchDone,
  input logic                        procDone,
  input logic                        fetchReq,
  input logic [ADDR_W-1:0]           fetchAddr,
  input logic [IDX_W-1:0]            hwPos,
  input logic [IDX_W-1:0]            completion,
  input logic [IDX_W-1:0]            postedKick,
  input logic                        kickErr
);
  localparam int MAX_SHIFT = IDX_W - MIN_LOG;

  logic [IDX_W-1:0] maskNow;
  always_comb begin
    maskNow = '0;
    for (int i = 0; i <= MAX_SHIFT; i++) begin
      if (int'(cfgWord[CODE_W:1]) == i || (i == MAX_SHIFT && int'(cfgWord[CODE_W:1]) > MAX_SHIFT))
        maskNow = IDX_W'(((IDX_W+1)'(1) << (i + MIN_LOG)) - 1'b1);
    end
  end

  // R3: no request with the channel disabled or the ring empty
  a_r3_idle_no_req: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgWord[0] || hwPos == postedKick) |-> !fetchReq);

  // R4: accepted fetch steps by one, modulo the ring size
  a_r4_fetch_step: assert property (@(posedge clk) disable iff (!rstN)
    (fetchReq && fetchDone) |=> hwPos == (($past(hwPos) + 1'b1) & $past(maskNow)));

  // R4: position holds without an accepted fetch
  a_r4_fetch_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(fetchReq && fetchDone) |=> $stable(hwPos));

  // R5: a processed-done with nothing outstanding is dropped
  a_r5_done_bound: assert property (@(posedge clk) disable iff (!rstN)
    (!procDone || completion == hwPos) |=> $stable(completion));

  // R2: an accepted kick is stored masked
  a_r2_kick_load: assert property (@(posedge clk) disable iff (!rstN)
    (kickValid && (!RECEIVE || kickIndex[1:0] == 2'b00))
      |=> postedKick == ($past(kickIndex) & $past(maskNow)));

  // R8: a misaligned receive kick is ignored and flagged
  a_r8_bad_kick: assert property (@(posedge clk) disable iff (!rstN)
    (RECEIVE && kickValid && kickIndex[1:0] != 2'b00) |=> ($stable(postedKick) && kickErr));

  // R8: error flag is sticky
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    kickErr |=> kickErr);

  // R6: entry 0 sits exactly at the aligned base
  a_r6_addr_base: assert property (@(posedge clk) disable iff (!rstN)
    (hwPos == '0) |-> fetchAddr == {baseHi, {ALIGN_LOG{1'b0}}});

endmodule

bind desc_ring_tracker desc_ring_tracker_chk #(
  .IDX_W(IDX_W), .ADDR_W(ADDR_W), .ALIGN_LOG(ALIGN_LOG), .DESC_LOG(DESC_LOG),
  .MIN_LOG(MIN_LOG), .CODE_W(CODE_W), .RECEIVE(RECEIVE)
) u_chk (.*);

// File: tb/desc_ring_tracker_test.sv
module desc_ring_tracker_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  cfgWord = '0;
  logic [52:0] baseHi = 53'h0A5_1234_5678;
  logic        kickValid = 1'b0;
  logic [12:0] kickIndex = '0;
  logic        fetchDone = 1'b0;
  logic        procDone = 1'b0;
  logic        fetchReq;
  logic [63:0] fetchAddr;
  logic [12:0] hwPos, completion, postedKick;
  logic        kickErr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  desc_ring_tracker uut (
    .clk(clk), .rstN(rstN), .cfgWord(cfgWord), .baseHi(baseHi),
    .kickValid(kickValid), .kickIndex(kickIndex), .fetchDone(fetchDone),
    .procDone(procDone), .fetchReq(fetchReq), .fetchAddr(fetchAddr),
    .hwPos(hwPos), .completion(completion), .postedKick(postedKick),
    .kickErr(kickErr)
  );

  function automatic logic [63:0] expAddr(input logic [12:0] idx);
    return {baseHi, 11'b0} + 64'(idx) * 64'd16;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; kickValid = 0; fetchDone = 0; procDone = 0; cfgWord = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic pulse(input bit kv, input logic [12:0] ki, input bit fd, input bit pd);
    @(negedge clk);
    kickValid = kv; kickIndex = ki; fetchDone = fd; procDone = pd;
    @(posedge clk);
    #1;
    kickValid = 0; fetchDone = 0; procDone = 0;
  endtask

  task automatic fetchN(input int n);
    for (int i = 0; i < n; i++) pulse(0, '0, 1, 0);
  endtask

  task automatic procN(input int n);
    for (int i = 0; i < n; i++) pulse(0, '0, 0, 1);
  endtask

  task automatic testReset();
    doReset();
    #1;
    check("R1 postedKick", postedKick, 0);
    check("R1 hwPos", hwPos, 0);
    check("R1 completion", completion, 0);
    check("R1 fetchReq", fetchReq, 0);
    check("R1 kickErr", kickErr, 0);
  endtask

  task automatic testBasic();
    doReset();
    cfgWord = 5'b00001;
    pulse(1, 13'd8, 0, 0);
    check("R2 kick stored", postedKick, 8);
    check("R3 req with work", fetchReq, 1);
    check("R6 addr entry0", fetchAddr, expAddr(0));
    fetchN(3);
    check("R4 three fetches", hwPos, 3);
    check("R6 addr entry3", fetchAddr, expAddr(3));
    procN(2);
    check("R5 two processed", completion, 2);
    procN(2);
    check("R5 capped at hwPos", completion, 3);
    fetchN(5);
    check("R3 empty at kick", fetchReq, 0);
    fetchN(1);
    check("R4 fetchDone while empty ignored", hwPos, 8);
  endtask

  task automatic testDisable();
    doReset();
    cfgWord = 5'b00001;
    pulse(1, 13'd4, 0, 0);
    @(negedge clk);
    cfgWord = 5'b00000;
    #1;
    check("R3 disabled no req", fetchReq, 0);
    fetchN(1);
    check("R4 fetchDone while disabled ignored", hwPos, 0);
    cfgWord = 5'b00001;
    #1;
    check("R3 re-enabled req", fetchReq, 1);
  endtask

  task automatic testBadKick();
    doReset();
    cfgWord = 5'b00001;
    pulse(1, 13'd8, 0, 0);
    pulse(1, 13'd13, 0, 0);
    check("R8 misaligned kick ignored", postedKick, 8);
    check("R8 error raised", kickErr, 1);
    pulse(1, 13'd12, 0, 0);
    check("R8 aligned kick accepted", postedKick, 12);
    check("R8 error sticky", kickErr, 1);
  endtask

  task automatic testWrap();
    doReset();
    cfgWord = 5'b00001;
    pulse(1, 13'd28, 0, 0);
    fetchN(28);
    procN(28);
    check("R9 caught up", completion, 28);
    pulse(1, 13'd4, 0, 0);
    fetchN(4);
    check("R9 hwPos wrapped to 0", hwPos, 0);
    check("R9 addr after wrap", fetchAddr, expAddr(0));
    fetchN(4);
    check("R9 hwPos past wrap", hwPos, 4);
    check("R3 empty after wrap", fetchReq, 0);
    procN(4);
    check("R9 completion wrapped", completion, 0);
    procN(4);
    check("R9 completion past wrap", completion, 4);
  endtask

  task automatic testSizes();
    doReset();
    cfgWord = {4'd3, 1'b1};
    pulse(1, 13'd300, 0, 0);
    check("R7 code3 mask 256", postedKick, 300 % 256);
    cfgWord = {4'd15, 1'b1};
    pulse(1, 13'd8188, 0, 0);
    check("R7 code15 as 8192", postedKick, 8188);
    cfgWord = {4'd8, 1'b1};
    pulse(1, 13'd8000, 0, 0);
    check("R7 code8 8192", postedKick, 8000);
    cfgWord = {4'd1, 1'b1};
    pulse(1, 13'd100, 0, 0);
    check("R7 code1 mask 64", postedKick, 100 % 64);
    cfgWord = {4'd0, 1'b1};
    pulse(1, 13'd44, 0, 0);
    check("R7 code0 mask 32", postedKick, 44 % 32);
  endtask

  task automatic testAddr();
    doReset();
    baseHi = 53'h1F_FFFF_FFFF_FF0;
    cfgWord = {4'd3, 1'b1};
    pulse(1, 13'd200, 0, 0);
    check("R6 base address", fetchAddr, expAddr(0));
    fetchN(130);
    check("R6 position 130", hwPos, 130);
    check("R6 address past 2KB", fetchAddr, expAddr(130));
  endtask

  task automatic testConcurrent();
    doReset();
    baseHi = 53'h0A5_1234_5678;
    cfgWord = 5'b00001;
    pulse(1, 13'd4, 0, 0);
    pulse(1, 13'd8, 1, 1);
    check("R10 kick with fetch: kick", postedKick, 8);
    check("R10 kick with fetch: step", hwPos, 1);
    check("R10 done judged on old state", completion, 0);
    pulse(0, '0, 1, 1);
    check("R10 fetch and done: hwPos", hwPos, 2);
    check("R10 fetch and done: completion", completion, 1);
    pulse(1, 13'd16, 1, 1);
    check("R10 triple: kick", postedKick, 16);
    check("R10 triple: hwPos", hwPos, 3);
    check("R10 triple: completion", completion, 2);
  endtask

  initial begin
    testReset();
    testBasic();
    testDisable();
    testBadKick();
    testWrap();
    testSizes();
    testAddr();
    testConcurrent();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule